// File: doc/BRIEF.md
# Single-Channel Block-Move DMA Engine

This block copies a run of words between one peripheral and memory without the processor. The processor loads a start address, a word count and a control word through a small register window. The window is reachable only while the processor still owns the buses. Writing the control word with its start bit set makes the engine ask for the buses. Once the buses are handed over, the engine places addresses on the memory address lines. It strobes one memory read or one memory write for each word the peripheral asks for, and it stops after the last word.

The read and write strobe lines are shared with the processor. While the grant is low they are register-access inputs. While the grant is high the engine drives them towards memory. The two directions come out as separate pins, with an output-enable that follows the grant. After the final word the engine drops its bus request, clears the start bit and sets a done flag. When enabled, that flag also raises an interrupt.

Top module: `blkmove_dma`

## Requirements
- R1: While reset is held and just after it is released, bus request, both memory strobes, the peripheral acknowledge, the interrupt and the memory address are 0, and every register reads back as 0.
- R2: With chip select high, the grant low and the write input high, the word on the write-data port is stored in the register chosen by `reg_sel_i`: 0 is the start address, 1 is the word count and 2 is control. Control bit 0 is start, bit 1 is direction (1 means memory write, 0 means memory read) and bit 2 is interrupt enable. Control bit 3 is the read-only done flag. With chip select, the read input and the grant low, the selected register appears on `cpu_rdata_o` in the same cycle. Selector 3 reads 0.
- R3: While the grant is high, register writes change nothing and register reads return 0.
- R4: A start write with a nonzero count raises bus request at the second clock edge after the write. No memory strobe or acknowledge occurs until the grant is high, even if the peripheral is already requesting.
- R5: With the grant high, each memory cycle lasts one clock and follows a peripheral request seen on the previous clock. During that cycle the acknowledge is high together with exactly one strobe, chosen by the direction bit.
- R6: During each memory cycle `mem_addr_o` carries the current address. It starts at the programmed value and increases by one per word, wrapping at the address width. Outside bus ownership `mem_addr_o` is 0.
- R7: The count drops by one per word. The cycle after the last word, bus request is low, start is clear and done is set. The address then reads back as the start plus the count and the count reads 0.
- R8: `irq_o` is high exactly when done and interrupt enable are both set. Any control write clears done.
- R9: A start with a count of 0 never raises bus request and sets done (with start cleared) at the next clock edge.
- R10: If the grant is withdrawn before a memory cycle, no strobe occurs and the count is unchanged. Bus request stays high and the transfer resumes when the grant returns.
- R11: `strobe_oe_o` equals `bus_grant_i` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Register window select |
| reg_sel_i | input | 2 | Register selector |
| rd_i | input | 1 | Register read strobe from processor (grant low) |
| wr_i | input | 1 | Register write strobe from processor (grant low) |
| cpu_wdata_i | input | DW | Register write data |
| cpu_rdata_o | output | DW | Register read data |
| bus_req_o | output | 1 | Bus request to processor |
| bus_grant_i | input | 1 | Bus grant from processor |
| periph_req_i | input | 1 | Peripheral asks for one word |
| periph_ack_o | output | 1 | One-cycle acknowledge of the word in progress |
| mem_addr_o | output | AW | Memory address while owning the buses |
| mem_rd_o | output | 1 | Memory read strobe (grant high) |
| mem_wr_o | output | 1 | Memory write strobe (grant high) |
| strobe_oe_o | output | 1 | Output-enable for the shared strobe lines |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench runs blocks that start near the top of the address range, so an engine that fails to wrap, or that compares the wrong address, reports a wrong strobe address or a wrong final address. It starts a block with a zero count. An engine that tests the count only after decrementing would ask for the buses and run through the whole count range. It withdraws the grant while the peripheral is requesting. A design that does not gate its strobes on the grant would fire a memory cycle on buses it does not own and lose a word from the count. Register writes during the grant are also tried, since an engine that misreads the shared strobe lines would overwrite its own address.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;

  // Register window selector values
  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } regsel_e;

  // Control word bit positions
  localparam int CTRL_START = 0;
  localparam int CTRL_DIR   = 1;
  localparam int CTRL_IEN   = 2;
  localparam int CTRL_DONE  = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_XFER = 2'd3
  } seq_state_e;

endpackage

// File: rtl/blkmove_regs.sv
module blkmove_regs
  import blkmove_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_wr,
  input  logic          acc_rd,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  input  logic          step,
  input  logic          finish,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] count_q,
  output logic          start_q,
  output logic          dir_q,
  output logic          ien_q,
  output logic          done_q
);

  localparam int AFIT = (AW < DW) ? AW : DW;
  localparam int CFIT = (CW < DW) ? CW : DW;

  regsel_e      sel_e;
  logic [AW-1:0] addr_d;
  logic [CW-1:0] count_d;
  logic          start_d, dir_d, ien_d, done_d;
  logic          addr_en, count_en, ctrl_en;
  logic          wr_addr, wr_count, wr_ctrl;

  assign sel_e    = regsel_e'(sel);
  assign wr_addr  = acc_wr && (sel_e == SEL_ADDR);
  assign wr_count = acc_wr && (sel_e == SEL_COUNT);
  assign wr_ctrl  = acc_wr && (sel_e == SEL_CTRL);

  assign addr_en  = wr_addr  || step;
  assign count_en = wr_count || step;
  assign ctrl_en  = wr_ctrl  || finish;

  // Next-state values
  always_comb begin
    addr_d  = addr_q;
    count_d = count_q;
    start_d = start_q;
    dir_d   = dir_q;
    ien_d   = ien_q;
    done_d  = done_q;
    if (wr_addr) begin
      addr_d = '0;
      addr_d[AFIT-1:0] = wdata[AFIT-1:0];
    end else if (step) begin
      addr_d = addr_q + 1'b1;
    end
    if (wr_count) begin
      count_d = '0;
      count_d[CFIT-1:0] = wdata[CFIT-1:0];
    end else if (step) begin
      count_d = count_q - 1'b1;
    end
    if (wr_ctrl) begin
      start_d = wdata[CTRL_START];
      dir_d   = wdata[CTRL_DIR];
      ien_d   = wdata[CTRL_IEN];
      done_d  = 1'b0;
    end else if (finish) begin
      start_d = 1'b0;
      done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      count_q <= '0;
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      ien_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (addr_en)  addr_q  <= addr_d;
      if (count_en) count_q <= count_d;
      if (ctrl_en) begin
        start_q <= start_d;
        dir_q   <= dir_d;
        ien_q   <= ien_d;
        done_q  <= done_d;
      end
    end
  end

  // Read path, combinational, zero when not selected
  always_comb begin
    rdata = '0;
    if (acc_rd) begin
      unique case (sel_e)
        SEL_ADDR:  rdata[AFIT-1:0] = addr_q[AFIT-1:0];
        SEL_COUNT: rdata[CFIT-1:0] = count_q[CFIT-1:0];
        SEL_CTRL: begin
          rdata[CTRL_START] = start_q;
          rdata[CTRL_DIR]   = dir_q;
          rdata[CTRL_IEN]   = ien_q;
          rdata[CTRL_DONE]  = done_q;
        end
        default:   rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/blkmove_seq.sv
module blkmove_seq
  import blkmove_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic count_zero,
  input  logic count_last,
  input  logic grant,
  input  logic preq,
  output logic bus_req,
  output logic step,
  output logic finish,
  output logic mem_cycle
);

  seq_state_e state_q, state_d;
  logic       state_en;

  always_comb begin
    state_d = state_q;
    step    = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (count_zero) finish  = 1'b1;
          else            state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (grant) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!grant)    state_d = ST_REQ;
        else if (preq) state_d = ST_XFER;
      end
      ST_XFER: begin
        if (!grant) begin
          state_d = ST_REQ;
        end else begin
          step = 1'b1;
          if (count_last) begin
            finish  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_WAIT;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_IDLE;
    else if (state_en) state_q <= state_d;
  end

  assign bus_req   = (state_q != ST_IDLE);
  assign mem_cycle = (state_q == ST_XFER) && grant;

endmodule

// File: rtl/blkmove_dma.sv
module blkmove_dma
  import blkmove_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic [1:0]    reg_sel_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          bus_req_o,
  input  logic          bus_grant_i,
  input  logic          periph_req_i,
  output logic          periph_ack_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          strobe_oe_o,
  output logic          irq_o
);

  logic          acc_wr, acc_rd;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] count_q;
  logic          start_q, dir_q, ien_q, done_q;
  logic          step, finish, mem_cycle, bus_req;
  logic          count_zero, count_last;

  // Shared strobes act as register-access inputs only without the grant
  assign acc_wr = cs_i && wr_i && !bus_grant_i;
  assign acc_rd = cs_i && rd_i && !bus_grant_i;

  assign count_zero = (count_q == '0);
  assign count_last = (count_q <= CW'(1));

  blkmove_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_wr  (acc_wr),
    .acc_rd  (acc_rd),
    .sel     (reg_sel_i),
    .wdata   (cpu_wdata_i),
    .step    (step),
    .finish  (finish),
    .rdata   (cpu_rdata_o),
    .addr_q  (addr_q),
    .count_q (count_q),
    .start_q (start_q),
    .dir_q   (dir_q),
    .ien_q   (ien_q),
    .done_q  (done_q)
  );

  blkmove_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_q),
    .count_zero (count_zero),
    .count_last (count_last),
    .grant      (bus_grant_i),
    .preq       (periph_req_i),
    .bus_req    (bus_req),
    .step       (step),
    .finish     (finish),
    .mem_cycle  (mem_cycle)
  );

  assign bus_req_o    = bus_req;
  assign periph_ack_o = mem_cycle;
  assign mem_rd_o     = mem_cycle && !dir_q;
  assign mem_wr_o     = mem_cycle &&  dir_q;
  assign mem_addr_o   = (bus_req && bus_grant_i) ? addr_q : '0;
  assign strobe_oe_o  = bus_grant_i;
  assign irq_o        = done_q && ien_q;

endmodule

// File: rtl/blkmove_chk.sv
module blkmove_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_grant_i,
  input logic          bus_req_o,
  input logic          periph_req_i,
  input logic          periph_ack_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic          irq_o
);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ack_o |=> !periph_ack_o);

  // R5
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ack_o |-> $past(periph_req_i));

  // R4
  strobe_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o) |-> (bus_grant_i && bus_req_o));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_ack_o ##1 (bus_grant_i && bus_req_o)) |->
      (mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));

  // R7
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req_o) |-> $past(periph_ack_o));

  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !bus_req_o);

endmodule

bind blkmove_dma blkmove_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_grant_i  (bus_grant_i),
  .bus_req_o    (bus_req_o),
  .periph_req_i (periph_req_i),
  .periph_ack_o (periph_ack_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .irq_o        (irq_o)
);

// File: tb/tb_blkmove_dma.sv
`timescale 1ns/1ps
module tb_blkmove_dma;

  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic          cs_i, rd_i, wr_i;
  logic [1:0]    reg_sel_i;
  logic [DW-1:0] cpu_wdata_i, cpu_rdata_o;
  logic          bus_req_o, bus_grant_i;
  logic          periph_req_i, periph_ack_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rd_o, mem_wr_o, strobe_oe_o, irq_o;

  int n_chk  = 0;
  int n_fail = 0;

  blkmove_dma #(.AW(AW), .CW(CW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .reg_sel_i(reg_sel_i),
    .rd_i(rd_i), .wr_i(wr_i), .cpu_wdata_i(cpu_wdata_i),
    .cpu_rdata_o(cpu_rdata_o), .bus_req_o(bus_req_o),
    .bus_grant_i(bus_grant_i), .periph_req_i(periph_req_i),
    .periph_ack_o(periph_ack_o), .mem_addr_o(mem_addr_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .strobe_oe_o(strobe_oe_o), .irq_o(irq_o)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Vector fields: [47:32] start address, [31:16] count, [15:8] request gap,
  // [1] interrupt enable, [0] direction
  localparam int NV = 4;
  localparam logic [47:0] VECS [NV] = '{
    48'h1000_0003_0000,
    48'hFFFE_0004_0203,
    48'h0040_0001_0101,
    48'h2000_0005_0302
  };

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [DW-1:0] d);
    @(negedge clk);
    cs_i = 1'b1; wr_i = 1'b1; reg_sel_i = s; cpu_wdata_i = d;
    @(negedge clk);
    cs_i = 1'b0; wr_i = 1'b0; cpu_wdata_i = '0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [DW-1:0] v);
    @(negedge clk);
    cs_i = 1'b1; rd_i = 1'b1; reg_sel_i = s;
    #1 v = cpu_rdata_o;
    cs_i = 1'b0; rd_i = 1'b0;
  endtask

  // Serve words with the grant already high until bus request drops
  task automatic run_words(input logic [AW-1:0] a, input int n,
                           input logic dir, input int gap);
    int seen = 0;
    int wait_cnt = 0;
    bit addr_ok = 1'b1;
    bit dir_ok = 1'b1;
    logic [AW-1:0] ea = a;
    periph_req_i = 1'b1;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      if (mem_rd_o || mem_wr_o) begin
        if (mem_addr_o != ea) addr_ok = 1'b0;
        if (mem_wr_o != dir || !periph_ack_o) dir_ok = 1'b0;
        seen++;
        ea = ea + 1'b1;
        if (gap > 0) begin
          periph_req_i = 1'b0;
          wait_cnt = gap;
        end
      end else if (!periph_req_i && wait_cnt > 0) begin
        wait_cnt--;
        if (wait_cnt == 0) periph_req_i = 1'b1;
      end
      if (!bus_req_o) break;
    end
    periph_req_i = 1'b0;
    chk(seen == n, "R7 word count", seen, n);
    chk(addr_ok, "R6 strobe addresses", addr_ok, 1);
    chk(dir_ok, "R5 strobe direction and ack", dir_ok, 1);
    chk(!bus_req_o, "R7 bus request released", bus_req_o, 0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    rst_n = 1'b0; cs_i = 1'b0; rd_i = 1'b0; wr_i = 1'b0; reg_sel_i = '0;
    cpu_wdata_i = '0; bus_grant_i = 1'b0; periph_req_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(!bus_req_o && !mem_rd_o && !mem_wr_o && !periph_ack_o && !irq_o && mem_addr_o == '0,
        "R1 outputs in reset", {bus_req_o, mem_rd_o, mem_wr_o, periph_ack_o, irq_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) begin
      rd_reg(2'(s), v);
      chk(v == '0, "R1 register reset value", v, 0);
    end
    chk(!bus_req_o && !irq_o, "R1 idle after reset", {bus_req_o, irq_o}, 0);

    // R2 register access
    wr_reg(2'd0, 16'h1234);
    wr_reg(2'd1, 16'hABCD);
    rd_reg(2'd0, v); chk(v == 16'h1234, "R2 address readback", v, 16'h1234);
    rd_reg(2'd1, v); chk(v == 16'hABCD, "R2 count readback", v, 16'hABCD);
    rd_reg(2'd3, v); chk(v == '0, "R2 unused selector", v, 0);

    // R3 access ignored under grant; R11 output enable
    bus_grant_i = 1'b1;
    wr_reg(2'd0, 16'h5555);
    rd_reg(2'd0, v); chk(v == '0, "R3 read under grant", v, 0);
    chk(strobe_oe_o == 1'b1, "R11 enable with grant", strobe_oe_o, 1);
    bus_grant_i = 1'b0;
    rd_reg(2'd0, v); chk(v == 16'h1234, "R3 write under grant ignored", v, 16'h1234);
    #1 chk(strobe_oe_o == 1'b0, "R11 enable without grant", strobe_oe_o, 0);

    // Table-driven transfers
    for (int i = 0; i < NV; i++) begin
      logic [47:0]   vec;
      logic [AW-1:0] a, ea;
      logic [CW-1:0] n;
      int            gap;
      logic          dir, ien;
      bit            quiet;
      vec = VECS[i];
      a = vec[47:32]; n = vec[31:16]; gap = int'(vec[15:8]);
      ien = vec[1]; dir = vec[0];
      ea = a + AW'(n);
      wr_reg(2'd0, a);
      wr_reg(2'd1, n);
      wr_reg(2'd2, {13'd0, ien, dir, 1'b1});
      chk(!bus_req_o, "R4 request not yet raised", bus_req_o, 0);
      periph_req_i = 1'b1;
      @(negedge clk);
      chk(bus_req_o, "R4 request raised", bus_req_o, 1);
      quiet = 1'b1;
      repeat (2) begin
        @(negedge clk);
        if (mem_rd_o || mem_wr_o || periph_ack_o || mem_addr_o != '0) quiet = 1'b0;
      end
      chk(quiet, "R4 no memory cycle before grant", quiet, 1);
      bus_grant_i = 1'b1;
      run_words(a, int'(n), dir, gap);
      bus_grant_i = 1'b0;
      rd_reg(2'd0, v); chk(v == ea, "R7 final address", v, ea);
      rd_reg(2'd1, v); chk(v == '0, "R7 final count", v, 0);
      rd_reg(2'd2, v);
      chk(v == {12'd0, 1'b1, ien, dir, 1'b0}, "R7 control after finish", v,
          {12'd0, 1'b1, ien, dir, 1'b0});
      chk(irq_o == ien, "R8 interrupt follows enable", irq_o, ien);
      wr_reg(2'd2, '0);
      #1 chk(!irq_o, "R8 control write clears done", irq_o, 0);
    end

    // R9 zero count
    begin
      bit never;
      wr_reg(2'd1, '0);
      wr_reg(2'd2, 16'h0005);
      never = !bus_req_o;
      @(negedge clk);
      never = never && !bus_req_o;
      rd_reg(2'd2, v);
      chk(v == 16'h000C, "R9 zero count completes at once", v, 16'h000C);
      chk(irq_o, "R9 interrupt on zero count", irq_o, 1);
      repeat (3) begin
        @(negedge clk);
        never = never && !bus_req_o;
      end
      chk(never, "R9 no bus request", never, 1);
      wr_reg(2'd2, '0);
    end

    // R10 grant withdrawn before the memory cycle
    begin
      bit quiet;
      wr_reg(2'd0, 16'h0300);
      wr_reg(2'd1, 16'd2);
      wr_reg(2'd2, 16'h0003);
      @(negedge clk);
      bus_grant_i = 1'b1; periph_req_i = 1'b0;
      repeat (2) @(negedge clk);
      bus_grant_i = 1'b0; periph_req_i = 1'b1;
      quiet = 1'b1;
      repeat (3) begin
        @(negedge clk);
        if (mem_rd_o || mem_wr_o || periph_ack_o || mem_addr_o != '0 || !bus_req_o)
          quiet = 1'b0;
      end
      chk(quiet, "R10 no strobe while grant withdrawn", quiet, 1);
      rd_reg(2'd1, v); chk(v == 16'd2, "R10 count unchanged", v, 2);
      bus_grant_i = 1'b1;
      run_words(16'h0300, 2, 1'b1, 0);
      bus_grant_i = 1'b0;
      rd_reg(2'd1, v); chk(v == '0, "R10 resumed to completion", v, 0);
      wr_reg(2'd2, '0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule